// File: doc/BRIEF.md
# Configurable interrupt source conditioner

This block conditions a bank of shared interrupt inputs. Each raw line is first brought into the clock domain through a two-flop synchroniser. It is then turned into a pending bit by its own sense settings: the active level or edge (polarity), level or edge sensing (trigger), and an option to respond to both edges. Software reaches the bank over a simple 32-bit register bus. Writes take one cycle, and reads return data combinationally in the same cycle.

Mask bits are never written directly. Two write-only registers change them: a 1 in the set register enables a line, a 1 in the clear register disables it, and 0 bits leave the line alone. A write-only injection register names one line and carries a set/clear flag. It can raise a software interrupt on an edge-sensed line, or acknowledge a latched edge. Pending and mask state can be read back 32 lines per word. The AND of pending and mask drives a vector that goes to the downstream routing logic.

Top module: `irq_cond_bank`

## Requirements
- R1: After reset, every existing line reads polarity 1, trigger 0, dual-edge 0 and mask 0, and the masked pending vector is all zero.
- R2: A read at byte offset 0x000 returns (N_IRQ/8 - 1) in bits [7:0] and zeros in all other bits.
- R3: Writing word k at 0x300+4k sets the mask of each line whose bit is 1, and writing at 0x400+4k clears it. Bits written as 0 leave the mask unchanged. The mask is read back at 0x200+4k.
- R4: irq_pend_o[i] is the pending bit of line i ANDed with its mask. Pending is read at 0x100+4k whether or not the line is masked.
- R5: With trigger 0 (level), a line is pending while its synchronised input equals its polarity bit (1 = high active, 0 = low active). An input change becomes visible after the second rising clock edge. A polarity change takes effect from the edge that writes it.
- R6: With trigger 1 and dual-edge 0, a rising synchronised edge (polarity 1) or a falling one (polarity 0) latches pending. The latched bit is visible after the third rising edge following the input change, and it stays set after the input returns.
- R7: With trigger 1 and dual-edge 1, both edges latch pending and polarity is ignored.
- R8: A write at 0x004 holds a line number in bits [10:0] and a flag in bit 31 (1 = set, 0 = clear). Set latches pending on an edge-mode line, and clear releases it. An edge detected in the same cycle as a clear stays latched. Numbers at or beyond N_IRQ are ignored, and the register has no effect on a level-mode line.
- R9: The polarity, trigger and dual-edge words are read/write at 0x500+4k, 0x600+4k and 0x700+4k. Setting a line's trigger to 0 discards its latched edge state.
- R10: Line i sits in word i/32, bit i%32. Bits for lines at or beyond N_IRQ read 0, words beyond the last one read 0, and write-only offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | N_IRQ | Raw asynchronous interrupt inputs |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_pend_o | output | N_IRQ | Pending AND mask, per line |

## Verification
The bench builds the bank with N_IRQ = 40. This gives two register words, and the second holds only eight real lines. The zero padding of bits 40 to 63 can therefore be checked, along with injection into a line in the second word, an injection number (45) that lies past the last line, and a read of the nonexistent third word. With forty lines the reference model can follow every line on every clock while random inputs and random configuration writes run, and a later clear can still be seen to leave a line held set by a simultaneous edge.

// File: rtl/irq_cond_pkg.sv
`timescale 1ns/1ps
package irq_cond_pkg;
  localparam int unsigned ADDR_W        = 12;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned WEDGE_NUM_W   = 11;
  localparam int unsigned WEDGE_SET_BIT = 31;
  localparam int unsigned CFG_W         = 8;

  // register block selected by addr[11:8]
  typedef enum logic [3:0] {
    BLK_MISC = 4'h0,
    BLK_PEND = 4'h1,
    BLK_MASK = 4'h2,
    BLK_MSET = 4'h3,
    BLK_MCLR = 4'h4,
    BLK_POL  = 4'h5,
    BLK_TRIG = 4'h6,
    BLK_DUAL = 4'h7
  } blk_e;

  localparam logic [5:0] MISC_CFG   = 6'd0;
  localparam logic [5:0] MISC_WEDGE = 6'd1;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] dly_o
);
  logic [W-1:0] meta_q, sync_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      dly_q  <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      dly_q  <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign dly_o  = dly_q;
endmodule

// File: rtl/irq_line_cond.sv
`timescale 1ns/1ps
module irq_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic dly_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic wset_i,
  input  logic wclr_i,
  output logic pend_o
);
  logic rise, fall, hit, level, latch_q;

  assign rise  = sync_i & ~dly_i;
  assign fall  = ~sync_i & dly_i;
  assign hit   = dual_i ? (rise | fall) : (pol_i ? rise : fall);
  assign level = ~(sync_i ^ pol_i);

  // edge and set win over a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= 1'b0;
    else if (!trig_i) latch_q <= 1'b0;
    else              latch_q <= (latch_q & ~wclr_i) | hit | wset_i;
  end

  assign pend_o = trig_i ? latch_q : level;
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_cond_pkg::*;
#(
  parameter int unsigned N_IRQ = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_IRQ-1:0]  pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_IRQ-1:0]  mask_o,
  output logic [N_IRQ-1:0]  pol_o,
  output logic [N_IRQ-1:0]  trig_o,
  output logic [N_IRQ-1:0]  dual_o,
  output logic [N_IRQ-1:0]  wset_o,
  output logic [N_IRQ-1:0]  wclr_o,
  output logic [N_IRQ-1:0]  mset_o,
  output logic [N_IRQ-1:0]  mclr_o
);
  localparam int unsigned N_WORDS = (N_IRQ + 31) / 32;
  localparam int unsigned PAD     = N_WORDS * 32;
  localparam int unsigned WIDX    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [3:0]             blk;
  logic [5:0]             word;
  logic                   addr_ok, word_ok;
  logic [WIDX-1:0]        word_idx;
  logic [N_WORDS-1:0]     wsel;
  logic [N_IRQ-1:0]       line_sel, wbit, pol_we, trig_we, dual_we;
  logic                   wedge_wr;
  logic [WEDGE_NUM_W-1:0] wnum;
  logic [N_IRQ-1:0]       mask_q, pol_q, trig_q, dual_q;

  assign blk      = addr_i[11:8];
  assign word     = addr_i[7:2];
  assign addr_ok  = (addr_i[1:0] == 2'b00);
  assign word_ok  = (32'(word) < N_WORDS);
  assign word_idx = word[WIDX-1:0];

  always_comb begin
    for (int w = 0; w < N_WORDS; w++)
      wsel[w] = wr_en_i && addr_ok && (word == 6'(w));
  end

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      line_sel[i] = wsel[i / 32];
      wbit[i]     = wdata_i[i % 32];
    end
  end

  assign mset_o  = line_sel & wbit & {N_IRQ{blk == BLK_MSET}};
  assign mclr_o  = line_sel & wbit & {N_IRQ{blk == BLK_MCLR}};
  assign pol_we  = line_sel & {N_IRQ{blk == BLK_POL}};
  assign trig_we = line_sel & {N_IRQ{blk == BLK_TRIG}};
  assign dual_we = line_sel & {N_IRQ{blk == BLK_DUAL}};

  // software injection: one line per write
  assign wedge_wr = wr_en_i && addr_ok && (blk == BLK_MISC) && (word == MISC_WEDGE);
  assign wnum     = wdata_i[WEDGE_NUM_W-1:0];

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      wset_o[i] = wedge_wr &&  wdata_i[WEDGE_SET_BIT] && (wnum == WEDGE_NUM_W'(i));
      wclr_o[i] = wedge_wr && !wdata_i[WEDGE_SET_BIT] && (wnum == WEDGE_NUM_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
      dual_q <= '0;
    end else begin
      mask_q <= (mask_q | mset_o) & ~mclr_o;
      pol_q  <= (pol_q  & ~pol_we)  | (wbit & pol_we);
      trig_q <= (trig_q & ~trig_we) | (wbit & trig_we);
      dual_q <= (dual_q & ~dual_we) | (wbit & dual_we);
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign dual_o = dual_q;

  logic [N_WORDS-1:0][31:0] pend_w, mask_w, pol_w, trig_w, dual_w;
  assign pend_w = PAD'(pend_i);
  assign mask_w = PAD'(mask_q);
  assign pol_w  = PAD'(pol_q);
  assign trig_w = PAD'(trig_q);
  assign dual_w = PAD'(dual_q);

  always_comb begin
    rdata_o = '0;
    if (addr_ok) begin
      if (blk == BLK_MISC) begin
        if (word == MISC_CFG) rdata_o = DATA_W'(CFG_W'(N_IRQ / 8 - 1));
      end else if (word_ok) begin
        case (blk)
          BLK_PEND: rdata_o = pend_w[word_idx];
          BLK_MASK: rdata_o = mask_w[word_idx];
          BLK_POL:  rdata_o = pol_w[word_idx];
          BLK_TRIG: rdata_o = trig_w[word_idx];
          BLK_DUAL: rdata_o = dual_w[word_idx];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_cond_bank.sv
`timescale 1ns/1ps
module irq_cond_bank
  import irq_cond_pkg::*;
#(
  parameter int unsigned N_IRQ = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_raw_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_IRQ-1:0]  irq_pend_o
);
  logic [N_IRQ-1:0] sync_q, dly_q, pend_all;
  logic [N_IRQ-1:0] mask_q, pol_q, trig_q, dual_q;
  logic [N_IRQ-1:0] wset, wclr, mset, mclr;

  irq_sync #(.W(N_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_raw_i),
    .sync_o (sync_q),
    .dly_o  (dly_q)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    irq_line_cond u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_q[i]),
      .dly_i  (dly_q[i]),
      .pol_i  (pol_q[i]),
      .trig_i (trig_q[i]),
      .dual_i (dual_q[i]),
      .wset_i (wset[i]),
      .wclr_i (wclr[i]),
      .pend_o (pend_all[i])
    );
  end

  irq_regs #(.N_IRQ(N_IRQ)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend_all),
    .rdata_o (rdata_o),
    .mask_o  (mask_q),
    .pol_o   (pol_q),
    .trig_o  (trig_q),
    .dual_o  (dual_q),
    .wset_o  (wset),
    .wclr_o  (wclr),
    .mset_o  (mset),
    .mclr_o  (mclr)
  );

  assign irq_pend_o = pend_all & mask_q;
endmodule

// File: rtl/irq_cond_chk.sv
`timescale 1ns/1ps
module irq_cond_chk #(
  parameter int unsigned N_IRQ = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IRQ-1:0] mask_i,
  input logic [N_IRQ-1:0] pol_i,
  input logic [N_IRQ-1:0] trig_i,
  input logic [N_IRQ-1:0] sync_i,
  input logic [N_IRQ-1:0] pend_all_i,
  input logic [N_IRQ-1:0] wset_i,
  input logic [N_IRQ-1:0] wclr_i,
  input logic [N_IRQ-1:0] mset_i,
  input logic [N_IRQ-1:0] mclr_i,
  input logic [N_IRQ-1:0] irq_pend_o
);
  a_r3_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mset_i) |=> ((mask_i & $past(mset_i)) == $past(mset_i)));

  a_r3_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mclr_i) |=> ((mask_i & $past(mclr_i)) == '0));

  a_r8_wedge_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wset_i) && $onehot0(wclr_i));

  a_r8_wedge_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wset_i & trig_i) != '0) |=>
      ((pend_all_i & $past(wset_i & trig_i)) == $past(wset_i & trig_i)));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    a_r5_level_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig_i[i] && mask_i[i]) |-> (irq_pend_o[i] == (sync_i[i] == pol_i[i])));

    a_r6_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[i] && pend_all_i[i] && !wclr_i[i]) |=> (pend_all_i[i] || !trig_i[i]));
  end
endmodule

bind irq_cond_bank irq_cond_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mask_i     (mask_q),
  .pol_i      (pol_q),
  .trig_i     (trig_q),
  .sync_i     (sync_q),
  .pend_all_i (pend_all),
  .wset_i     (wset),
  .wclr_i     (wclr),
  .mset_i     (mset),
  .mclr_i     (mclr),
  .irq_pend_o (irq_pend_o)
);

// File: tb/irq_cond_bank_bench.sv
`timescale 1ns/1ps
module irq_cond_bank_bench;
  localparam int BN = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BN-1:0] raw = '0;
  logic          wr_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [BN-1:0] pend_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irq_cond_bank #(.N_IRQ(BN)) u_irq_cond_bank (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_raw_i  (raw),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_pend_o (pend_o)
  );

  // behavioural reference state
  bit [BN-1:0] m_s1, m_s2, m_s3, m_lat, m_mask, m_pol, m_trig, m_dual;

  function automatic bit [BN-1:0] m_pend();
    bit [BN-1:0] p;
    for (int i = 0; i < BN; i++)
      p[i] = m_trig[i] ? m_lat[i] : (m_s2[i] == m_pol[i]);
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_lat = '0;
      m_mask = '0; m_pol = '1; m_trig = '0; m_dual = '0;
    end else begin
      bit [BN-1:0] n_lat;
      int blk, wi, wn;
      bit wed, wflag;
      blk = 0; wi = 0; wn = -1; wed = 0; wflag = 0;
      if (wr_en && addr[1:0] == 2'b00) begin
        blk = int'(addr[11:8]);
        wi  = int'(addr[7:2]);
        if (blk == 0 && wi == 1) begin
          wed = 1; wflag = wdata[31]; wn = int'(wdata[10:0]);
        end
      end
      for (int i = 0; i < BN; i++) begin
        bit up, dn, ev;
        up = m_s2[i] && !m_s3[i];
        dn = !m_s2[i] && m_s3[i];
        if (m_dual[i]) ev = up || dn;
        else if (m_pol[i]) ev = up;
        else ev = dn;
        if (!m_trig[i]) n_lat[i] = 0;
        else if (ev || (wed && wflag && wn == i)) n_lat[i] = 1;
        else if (wed && !wflag && wn == i) n_lat[i] = 0;
        else n_lat[i] = m_lat[i];
      end
      m_lat = n_lat;
      if (wr_en && addr[1:0] == 2'b00 && blk >= 3 && blk <= 7) begin
        for (int b = 0; b < 32; b++) begin
          int ln;
          ln = wi * 32 + b;
          if (ln < BN) begin
            case (blk)
              3: if (wdata[b]) m_mask[ln] = 1;
              4: if (wdata[b]) m_mask[ln] = 0;
              5: m_pol[ln]  = wdata[b];
              6: m_trig[ln] = wdata[b];
              7: m_dual[ln] = wdata[b];
              default: ;
            endcase
          end
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = raw;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // every clock: masked pending output against the model
  always @(negedge clk) begin
    if (rst_n && !done) chk("R4 masked vector", 64'(pend_o), 64'(m_pend() & m_mask));
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic rd_bit(string req, logic [11:0] a, int b, bit exp);
    addr = a;
    #1;
    chk(req, 64'(rdata[b]), 64'(exp));
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    logic [31:0] w0, w1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 pend_o after reset", 64'(pend_o), 64'd0);
    rd_chk("R1 polarity word0", 12'h500, 32'hFFFF_FFFF);
    rd_chk("R1 polarity word1 (R10 padding)", 12'h504, 32'h0000_00FF);
    rd_chk("R1 trigger word0", 12'h600, 32'h0);
    rd_chk("R1 dual word1", 12'h704, 32'h0);
    rd_chk("R1 mask word0", 12'h200, 32'h0);
    rd_chk("R1 pending word0", 12'h100, 32'h0);
    // R2 configuration field
    rd_chk("R2 config", 12'h000, 32'd4);
    // R10 absent word and write-only reads
    rd_chk("R10 word2 absent", 12'h508, 32'h0);
    rd_chk("R10 wedge reads zero", 12'h004, 32'h0);
    rd_chk("R10 set-mask reads zero", 12'h300, 32'h0);

    // R3 mask set/clear
    wr(12'h300, 32'h0000_00F0);
    rd_chk("R3 set-mask", 12'h200, 32'h0000_00F0);
    wr(12'h300, 32'h0);
    rd_chk("R3 zero bits no effect", 12'h200, 32'h0000_00F0);
    wr(12'h400, 32'h0000_0030);
    rd_chk("R3 clear-mask", 12'h200, 32'h0000_00C0);
    wr(12'h304, 32'hFFFF_FFFF);
    rd_chk("R10 mask word1 padding", 12'h204, 32'h0000_00FF);
    wr(12'h300, 32'hFFFF_FFFF);

    // R5 level sensing
    raw[3] = 1'b1;
    cyc(1);
    rd_bit("R5 level after one edge", 12'h100, 3, 1'b0);
    cyc(1);
    rd_bit("R5 level after two edges", 12'h100, 3, 1'b1);
    wr(12'h500, 32'h0);
    rd_chk("R5 low-active word0", 12'h100, 32'hFFFF_FFF7);
    wr(12'h500, 32'hFFFF_FFFF);
    raw[3] = 1'b0;
    cyc(3);

    // R6 rising edge on line 8
    wr(12'h600, 32'h0000_0100);
    raw[8] = 1'b1;
    cyc(2);
    rd_bit("R6 edge not yet latched", 12'h100, 8, 1'b0);
    cyc(1);
    rd_bit("R6 rising edge latched", 12'h100, 8, 1'b1);
    raw[8] = 1'b0;
    cyc(5);
    rd_bit("R6 latch held after input low", 12'h100, 8, 1'b1);
    wr(12'h004, 32'h0000_0008);
    rd_bit("R8 wedge clear acknowledges", 12'h100, 8, 1'b0);

    // R6 falling edge
    wr(12'h500, 32'hFFFF_FEFF);
    raw[8] = 1'b1;
    cyc(4);
    rd_bit("R6 rise ignored with pol 0", 12'h100, 8, 1'b0);
    raw[8] = 1'b0;
    cyc(3);
    rd_bit("R6 falling edge latched", 12'h100, 8, 1'b1);
    wr(12'h004, 32'h0000_0008);

    // R7 dual edge
    wr(12'h700, 32'h0000_0100);
    raw[8] = 1'b1;
    cyc(3);
    rd_bit("R7 dual rise", 12'h100, 8, 1'b1);
    wr(12'h004, 32'h0000_0008);
    rd_bit("R7 cleared", 12'h100, 8, 1'b0);
    raw[8] = 1'b0;
    cyc(3);
    rd_bit("R7 dual fall", 12'h100, 8, 1'b1);
    wr(12'h004, 32'h0000_0008);
    wr(12'h700, 32'h0);
    wr(12'h500, 32'hFFFF_FFFF);

    // R8 wedge set, then clear concurrent with an edge
    wr(12'h004, 32'h8000_0008);
    rd_bit("R8 wedge set edge line", 12'h100, 8, 1'b1);
    raw[8] = 1'b1;
    cyc(1);
    wr(12'h004, 32'h0000_0008);
    rd_bit("R8 edge beats concurrent clear", 12'h100, 8, 1'b1);
    wr(12'h004, 32'h0000_0008);
    rd_bit("R8 later clear releases", 12'h100, 8, 1'b0);
    raw[8] = 1'b0;
    cyc(3);

    // R4 masked line keeps pending
    wr(12'h004, 32'h8000_0008);
    wr(12'h400, 32'h0000_0100);
    chk("R4 masked line output low", 64'(pend_o[8]), 64'd0);
    rd_bit("R4 pending still readable", 12'h100, 8, 1'b1);
    rd_bit("R3 mask bit cleared", 12'h200, 8, 1'b0);
    wr(12'h300, 32'h0000_0100);
    chk("R4 unmasked line output high", 64'(pend_o[8]), 64'd1);

    // R8 level line and out-of-range number
    wr(12'h004, 32'h8000_0005);
    rd_bit("R8 no effect on level line", 12'h100, 5, 1'b0);
    rd_chk("R8 pre word0", 12'h100, 32'h0000_0100);
    w0 = rdata;
    rd_chk("R8 pre word1", 12'h104, 32'h0);
    w1 = rdata;
    wr(12'h004, 32'h8000_002D);
    rd_chk("R8 out-of-range word0", 12'h100, w0);
    rd_chk("R8 out-of-range word1", 12'h104, w1);

    // R10 line in the second word
    wr(12'h604, 32'h0000_0002);
    wr(12'h004, 32'h8000_0021);
    rd_chk("R10 line 33 in word1 bit1", 12'h104, 32'h0000_0002);
    chk("R10 line 33 output", 64'(pend_o[33]), 64'd1);

    // R9 trigger back to level discards latch
    wr(12'h600, 32'h0);
    rd_bit("R9 level view of line 8", 12'h100, 8, 1'b0);
    wr(12'h600, 32'h0000_0100);
    rd_bit("R9 latch discarded", 12'h100, 8, 1'b0);
    rd_chk("R9 trigger readback", 12'h600, 32'h0000_0100);
    wr(12'h704, 32'hFFFF_FFFF);
    rd_chk("R9 dual readback padded", 12'h704, 32'h0000_00FF);
    wr(12'h704, 32'h0);

    // random phase, model compared each clock
    for (int it = 0; it < 600; it++) begin
      @(negedge clk);
      raw = BN'({$urandom, $urandom});
      if ($urandom % 3 == 0) begin
        int sel;
        sel = $urandom % 6;
        wr_en = 1'b1;
        if (sel == 5) begin
          addr = 12'h004;
          wdata = {$urandom % 2 == 0, 20'd0, 11'($urandom % 48)};
        end else begin
          addr = {4'(sel + 3), 6'($urandom % 2), 2'b00};
          wdata = $urandom;
        end
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    cyc(2);
    begin
      bit [63:0] pv;
      pv = 64'(m_pend());
      rd_chk("R6 R7 random pending word0", 12'h100, pv[31:0]);
      rd_chk("R6 R7 random pending word1", 12'h104, pv[63:32]);
    end
    finish_run();
  end
endmodule